// File: doc/BRIEF.md
# Display link interrupt controller

This block holds the interrupt status and enable state for a serial display link engine. The engine raises single-cycle event pulses: read data ready, command done, tearing-effect ready, video frame done and external tearing-effect ready. Each pulse is latched into a sticky status bit whether or not that event is enabled. The AND of status and enable drives a single active-low, level-sensitive interrupt line. The status word also carries a live, read-only engine-busy flag. A separate acknowledge register produces a one-cycle release strobe toward the engine after a read.

Software reaches the block through a plain register port. A write carries an address, data and a per-bit mask, and read data is returned combinationally for the current address. To clear status bits, software writes zeros under the mask. To consume a read event, software pulses the acknowledge register and polls the busy bit until it reads 0. There is no data stream at this block, so every pin is a plain control or status signal without a handshake.

Top module: `dlink_irq_ctrl`

## Requirements
- R1: Event input bit i sets status bit i on the next clock edge whether or not enable bit i is set. The positions are bit 0 read-ready, bit 1 command-done, bit 2 tearing-ready, bit 3 frame-done and bit 4 external-tearing-ready. Status is read at address 1.
- R2: The enable register is at address 0 and uses the same five bit positions. On a write, each bit under the mask takes the data bit and each bit outside the mask keeps its value. Upper bits read as 0.
- R3: On a write to address 1, a status bit is cleared when its mask bit is 1 and its data bit is 0. Writing a 1 leaves the bit unchanged, and bits outside the mask are preserved.
- R4: When an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: The interrupt output goes low one cycle after any status bit is set while its enable bit is set. It returns high one cycle after no enabled status bit remains.
- R6: Bit 31 of the status read equals the engine-busy input in the same cycle. Writes never change it.
- R7: A write to address 2 with data bit 0 and mask bit 0 both set drives the acknowledge strobe high for exactly the next cycle. Address 2 and every unused address read as 0.
- R8: After reset, status and enable are 0, the interrupt output is high and the acknowledge strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 enable, 1 status, 2 acknowledge) |
| reg_wdata | input | 32 | Write data |
| reg_wmask | input | 32 | Per-bit write mask |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| evt_i | input | 5 | Event pulses from the engine |
| busy_i | input | 1 | Engine busy level |
| irq_n | output | 1 | Active-low interrupt |
| rack_o | output | 1 | Read-acknowledge strobe to the engine |

## Verification
A wrong status bit shows up in the readback of address 1 in the cycle after the event or write that caused it. Unless that bit is disabled, irq_n also changes one cycle later. A lost set-over-clear race or a clear that leaks outside the mask appears as a bit missing or dropped in that same readback. A stuck enable bit, or a late or missing acknowledge strobe, shows on irq_n or rack_o within one cycle of the triggering write. The bench compares a behavioural model against all three outputs on every clock, under directed corners and pseudo-random traffic.

// File: rtl/dlink_irq_pkg.sv
package dlink_irq_pkg;
  localparam int DATA_W  = 32;
  localparam int NUM_EVT = 5;
  localparam int ADDR_W  = 2;
  localparam int BUSY_POS = DATA_W - 1;

  typedef enum logic [ADDR_W-1:0] {
    ADR_ENABLE = 2'd0,
    ADR_STATUS = 2'd1,
    ADR_ACK    = 2'd2
  } reg_adr_e;
endpackage

// File: rtl/dlink_irq_stat_bank.sv
module dlink_irq_stat_bank #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [N-1:0] wdata,
  input  logic [N-1:0] wmask,
  input  logic [N-1:0] evt,
  output logic [N-1:0] stat
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic clr;
    assign clr = wr & wmask[i] & ~wdata[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat[i] <= 1'b0;
      else        stat[i] <= evt[i] | (stat[i] & ~clr);
    end

    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> stat[i]); // R4
    AST_CLEAR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!evt[i] && clr) |=> !stat[i]); // R3
    AST_UNMASKED_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (!evt[i] && !(wr && wmask[i])) |=> $stable(stat[i])); // R3
  end
endmodule

// File: rtl/dlink_irq_en_reg.sv
module dlink_irq_en_reg #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [N-1:0] wdata,
  input  logic [N-1:0] wmask,
  output logic [N-1:0] en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  en <= '0;
    else if (wr) en <= (en & ~wmask) | (wdata & wmask);
  end

  AST_EN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(en)); // R2
endmodule

// File: rtl/dlink_irq_gate.sv
module dlink_irq_gate #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] stat,
  input  logic [N-1:0] en,
  input  logic         ack_req,
  output logic         irq_n,
  output logic         rack
);
  logic pend;
  assign pend = |(stat & en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_n <= 1'b1;
      rack  <= 1'b0;
    end else begin
      irq_n <= ~pend;
      rack  <= ack_req;
    end
  end

  AST_IRQ_ASSERTS: assert property (@(posedge clk) disable iff (!rst_n)
    pend |=> !irq_n); // R5
  AST_IRQ_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    !pend |=> irq_n); // R5
  AST_RACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |=> rack); // R7
  AST_RACK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_req |=> !rack); // R7
endmodule

// File: rtl/dlink_irq_ctrl.sv
module dlink_irq_ctrl
  import dlink_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] reg_wmask,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic              busy_i,
  output logic              irq_n,
  output logic              rack_o
);
  logic [NUM_EVT-1:0] stat, en;
  logic wr_stat, wr_en, ack_req;
  logic unused_bits;

  assign wr_stat = reg_we && (reg_addr == ADR_STATUS);
  assign wr_en   = reg_we && (reg_addr == ADR_ENABLE);
  assign ack_req = reg_we && (reg_addr == ADR_ACK) && reg_wdata[0] && reg_wmask[0];
  assign unused_bits = ^{reg_wdata[DATA_W-1:NUM_EVT], reg_wmask[DATA_W-1:NUM_EVT]};

  dlink_irq_stat_bank #(.N(NUM_EVT)) u_stat (
    .clk(clk), .rst_n(rst_n), .wr(wr_stat),
    .wdata(reg_wdata[NUM_EVT-1:0]), .wmask(reg_wmask[NUM_EVT-1:0]),
    .evt(evt_i), .stat(stat));

  dlink_irq_en_reg #(.N(NUM_EVT)) u_en (
    .clk(clk), .rst_n(rst_n), .wr(wr_en),
    .wdata(reg_wdata[NUM_EVT-1:0]), .wmask(reg_wmask[NUM_EVT-1:0]),
    .en(en));

  dlink_irq_gate #(.N(NUM_EVT)) u_gate (
    .clk(clk), .rst_n(rst_n), .stat(stat), .en(en),
    .ack_req(ack_req), .irq_n(irq_n), .rack(rack_o));

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADR_ENABLE: reg_rdata[NUM_EVT-1:0] = en;
      ADR_STATUS: begin
        reg_rdata[NUM_EVT-1:0] = stat;
        reg_rdata[BUSY_POS]    = busy_i;
      end
      default: reg_rdata = '0;
    endcase
  end

  AST_EVT_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> (|stat)); // R1
endmodule

// File: tb/dlink_irq_ctrl_tb_top.sv
module dlink_irq_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd1;
  logic [31:0] reg_wdata = '0, reg_wmask = '0, reg_rdata;
  logic [4:0] evt_i = '0;
  logic busy_i = 1'b0;
  logic irq_n, rack_o;

  int checks = 0, errors = 0;
  int m_stat = 0, m_en = 0;
  bit m_irq_n = 1'b1, m_rack = 1'b0;

  always #10 clk = ~clk;

  dlink_irq_ctrl dut_i (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_wmask(reg_wmask), .reg_rdata(reg_rdata),
    .evt_i(evt_i), .busy_i(busy_i), .irq_n(irq_n), .rack_o(rack_o));

  // behavioural reference, advanced on every rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stat = 0; m_en = 0; m_irq_n = 1'b1; m_rack = 1'b0;
    end else begin
      int ns, ne;
      m_irq_n = ((m_stat & m_en) == 0);
      m_rack  = reg_we && reg_addr == 2'd2 && reg_wdata[0] && reg_wmask[0];
      ns = m_stat; ne = m_en;
      if (reg_we && reg_addr == 2'd1)
        ns = ns & ~(int'(reg_wmask[4:0]) & ~int'(reg_wdata[4:0]));
      ns = ns | int'(evt_i);
      if (reg_we && reg_addr == 2'd0)
        ne = (ne & ~int'(reg_wmask[4:0])) | (int'(reg_wdata[4:0]) & int'(reg_wmask[4:0]));
      m_stat = ns & 31; m_en = ne & 31;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_rdata();
    case (reg_addr)
      2'd0: return 32'(m_en);
      2'd1: return {busy_i, 26'd0, m_stat[4:0]};
      default: return 32'd0;
    endcase
  endfunction

  task automatic step();
    @(negedge clk);
    chk(reg_addr == 2'd0 ? "R2 rdata" : reg_addr == 2'd1 ? "R3 rdata" : "R7 rdata",
        reg_rdata, m_rdata());
    chk("R5 irq_n", 32'(irq_n), 32'(m_irq_n));
    chk("R7 rack", 32'(rack_o), 32'(m_rack));
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [31:0] m);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d; reg_wmask = m;
  endtask

  task automatic idle(input logic [1:0] a);
    reg_we = 1'b0; reg_addr = a; reg_wdata = '0; reg_wmask = '0; evt_i = '0;
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] lfsr = 32'hACE1_1234;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    step();
    chk("R8 status", reg_rdata, 32'd0);
    chk("R8 irq_n", 32'(irq_n), 32'd1);
    reg_addr = 2'd0; #1;
    chk("R8 enable", reg_rdata, 32'd0);
    chk("R8 rack", 32'(rack_o), 32'd0);

    // R1: event latched while disabled, no interrupt
    idle(2'd1); evt_i = 5'b00100; step();
    evt_i = '0;
    chk("R1 latched", reg_rdata, 32'h4);
    step();
    chk("R1 gated", 32'(irq_n), 32'd1);

    // R2/R5: enable it, irq low one cycle later
    wr(2'd0, 32'h4, 32'h1F); step();
    idle(2'd0);
    chk("R2 enable", reg_rdata, 32'h4);
    step();
    chk("R5 low", 32'(irq_n), 32'd0);

    // R4: clear collides with the event
    wr(2'd1, 32'h0, 32'h4); evt_i = 5'b00100; step();
    idle(2'd1);
    chk("R4 set wins", reg_rdata, 32'h4);

    // R3: writing 1 does nothing; clear outside mask leaves bits
    evt_i = 5'b00011; step();
    wr(2'd1, 32'hFFFF_FFFF, 32'h1F); evt_i = '0; step();
    chk("R3 write one", reg_rdata, 32'h7);
    wr(2'd1, 32'h0, 32'h4); step();
    idle(2'd1);
    chk("R3 masked clear", reg_rdata, 32'h3);
    step();
    chk("R5 high", 32'(irq_n), 32'd1);

    // R6: busy is live and read-only
    busy_i = 1'b1; #1;
    chk("R6 busy", reg_rdata, 32'h8000_0003);
    wr(2'd1, 32'h0, 32'h8000_0000); busy_i = 1'b0; step();
    idle(2'd1);
    chk("R6 not latched", reg_rdata, 32'h3);

    // R7: acknowledge strobe for one cycle
    wr(2'd2, 32'h1, 32'h0); step();
    chk("R7 needs mask", 32'(rack_o), 32'd0);
    wr(2'd2, 32'h1, 32'h1); step();
    idle(2'd2);
    chk("R7 strobe", 32'(rack_o), 32'd1);
    step();
    chk("R7 single", 32'(rack_o), 32'd0);

    // pseudo-random traffic against the model
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      reg_we    = lfsr[3] & lfsr[7];
      reg_addr  = lfsr[9:8];
      reg_wdata = {lfsr[15:0], lfsr[31:16]};
      reg_wmask = lfsr ^ {lfsr[7:0], lfsr[31:8]};
      evt_i     = (lfsr[12:10] == 3'd0) ? lfsr[20:16] : 5'd0;
      busy_i    = lfsr[25];
      step();
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule